// File: doc/BRIEF.md
# Shared Video Memory Access Arbiter

This block sits in front of a small character video memory that two agents want to use: the processor, which reads and writes display characters, and the display refresh counters, which fetch one character cell after another to paint the screen. An active-low select from the processor's address decoder decides who drives the memory. While the select is low the processor's address and its read and write strobes reach the memory. At all other times the refresh path owns it. The refresh address, built from a 4-bit row and a 6-bit column, drives the memory, the write enable is held inactive and the processor's data buffer stays shut.

Ownership follows two named states, evaluated combinationally in every cycle. OWN_REFRESH is the default state, entered whenever the select is high. OWN_CPU is entered whenever the select is low. There are two transitions: SEIZE (OWN_REFRESH to OWN_CPU, on the select falling) and RELEASE (OWN_CPU to OWN_REFRESH, on the select rising). Each fetch the display makes while the processor holds the memory returns the wrong data. A flag marks those cycles so that on-screen streaks can be modelled downstream.

Top module: `vram_share_arb`

## Requirements
- R1: With `cpu_sel_n` high, `mem_addr` equals the refresh address `{ref_row, ref_col}`.
- R2: With `cpu_sel_n` low, `mem_addr` equals `cpu_addr` bit for bit.
- R3: With `cpu_sel_n` high, `mem_we_n` is 1 for every value of `cpu_wr_n`, so the refresh path can never write.
- R4: With `cpu_sel_n` high, `rd_buf_en_n` is 1 for every value of `cpu_rd_n`, so the data buffer is off.
- R5: With `cpu_sel_n` low, `mem_we_n` equals `cpu_wr_n`.
- R6: With `cpu_sel_n` low, `rd_buf_en_n` equals `cpu_rd_n`.
- R7: `refresh_corrupt` is 1 exactly when `cpu_sel_n` is 0 and `ref_visible` is 1, and 0 in all other cases.
- R8: The refresh address places the row in bits 9:6 and the column in bits 5:0. Row 0, column 0 maps to address 0 and row 15, column 63 maps to address 1023.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_sel_n | input | 1 | Active-low processor claim, from the address decoder |
| cpu_addr | input | 10 | Processor address into video memory |
| cpu_wr_n | input | 1 | Processor write strobe, active low |
| cpu_rd_n | input | 1 | Processor read strobe, active low |
| ref_col | input | 6 | Refresh column counter |
| ref_row | input | 4 | Refresh row counter |
| ref_visible | input | 1 | High while the display fetches a visible cell |
| mem_addr | output | 10 | Address to the video memory |
| mem_we_n | output | 1 | Video memory write enable, active low |
| rd_buf_en_n | output | 1 | Processor read data buffer enable, active low |
| refresh_corrupt | output | 1 | High while a visible fetch is lost to the processor |

## Verification
The embedded checks watch the decoded ownership state on every evaluation. They confirm that OWN_REFRESH never lets a write strobe or the read buffer through, that the address matches the owner's source, and that the corruption flag matches the ownership state and the visibility input. The bench covers what those checks cannot show alone. It sweeps all 1024 row and column pairs against every combination of select, strobes and visibility. This proves the bit placement of the refresh address, including the two corner cells. It also shows that the strobes pass through unchanged in OWN_CPU.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;
    parameter int COL_BITS = 6;
    parameter int ROW_BITS = 4;
    localparam int ADDR_BITS = COL_BITS + ROW_BITS;

    typedef enum logic {
        OWN_REFRESH = 1'b0,
        OWN_CPU     = 1'b1
    } owner_e;
endpackage

// File: rtl/vram_owner_sel.sv
module vram_owner_sel
    import vram_arb_pkg::*;
(
    input  logic   sel_n,
    output owner_e owner
);
    always_comb begin
        unique case (sel_n)
            1'b0:    owner = OWN_CPU;
            default: owner = OWN_REFRESH;
        endcase
    end
endmodule

// File: rtl/vram_addr_mux.sv
module vram_addr_mux
    import vram_arb_pkg::*;
#(
    parameter int WIDTH = 10
) (
    input  owner_e           owner,
    input  logic [WIDTH-1:0] cpu_side,
    input  logic [WIDTH-1:0] ref_side,
    output logic [WIDTH-1:0] dout
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            unique case (owner)
                OWN_CPU:     dout[b] = cpu_side[b];
                OWN_REFRESH: dout[b] = ref_side[b];
                default:     dout[b] = ref_side[b];
            endcase
        end
    end
endmodule

// File: rtl/vram_strobe_gate.sv
module vram_strobe_gate
    import vram_arb_pkg::*;
(
    input  owner_e owner,
    input  logic   wr_in_n,
    input  logic   rd_in_n,
    input  logic   visible,
    output logic   we_out_n,
    output logic   buf_out_n,
    output logic   corrupt
);
    always_comb begin
        we_out_n  = 1'b1;
        buf_out_n = 1'b1;
        corrupt   = 1'b0;
        unique case (owner)
            OWN_CPU: begin
                we_out_n  = wr_in_n;
                buf_out_n = rd_in_n;
                corrupt   = visible;
            end
            OWN_REFRESH: begin
                we_out_n  = 1'b1;
                buf_out_n = 1'b1;
                corrupt   = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/vram_share_arb.sv
module vram_share_arb
    import vram_arb_pkg::*;
#(
    parameter int COLW = COL_BITS,
    parameter int ROWW = ROW_BITS,
    localparam int AW  = COLW + ROWW
) (
    input  logic            cpu_sel_n,
    input  logic [AW-1:0]   cpu_addr,
    input  logic            cpu_wr_n,
    input  logic            cpu_rd_n,
    input  logic [COLW-1:0] ref_col,
    input  logic [ROWW-1:0] ref_row,
    input  logic            ref_visible,
    output logic [AW-1:0]   mem_addr,
    output logic            mem_we_n,
    output logic            rd_buf_en_n,
    output logic            refresh_corrupt
);
    owner_e        owner;
    logic [AW-1:0] ref_addr;

    assign ref_addr = {ref_row, ref_col};

    vram_owner_sel u_owner (
        .sel_n (cpu_sel_n),
        .owner (owner)
    );

    vram_addr_mux #(.WIDTH(AW)) u_mux (
        .owner    (owner),
        .cpu_side (cpu_addr),
        .ref_side (ref_addr),
        .dout     (mem_addr)
    );

    vram_strobe_gate u_gate (
        .owner     (owner),
        .wr_in_n   (cpu_wr_n),
        .rd_in_n   (cpu_rd_n),
        .visible   (ref_visible),
        .we_out_n  (mem_we_n),
        .buf_out_n (rd_buf_en_n),
        .corrupt   (refresh_corrupt)
    );

    always_comb begin
        if (owner == OWN_REFRESH) begin
            assert_refresh_addr_R1: assert (mem_addr[COLW-1:0] == ref_col && mem_addr[AW-1:COLW] == ref_row);
            assert_no_refresh_write_R3: assert (mem_we_n);
            assert_buffer_off_R4: assert (rd_buf_en_n);
        end else begin
            assert_cpu_addr_R2: assert (mem_addr == cpu_addr);
            assert_write_pass_R5: assert (mem_we_n == cpu_wr_n);
            assert_read_pass_R6: assert (rd_buf_en_n == cpu_rd_n);
        end
        assert_corrupt_flag_R7: assert (refresh_corrupt == ((owner == OWN_CPU) && ref_visible));
    end
endmodule

// File: tb/sim_vram_share_arb.sv
module sim_vram_share_arb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic       cpu_sel_n = 1'b1;
    logic [9:0] cpu_addr = '0;
    logic       cpu_wr_n = 1'b1;
    logic       cpu_rd_n = 1'b1;
    logic [5:0] ref_col = '0;
    logic [3:0] ref_row = '0;
    logic       ref_visible = 1'b0;
    logic [9:0] mem_addr;
    logic       mem_we_n;
    logic       rd_buf_en_n;
    logic       refresh_corrupt;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    vram_share_arb u0 (
        .cpu_sel_n       (cpu_sel_n),
        .cpu_addr        (cpu_addr),
        .cpu_wr_n        (cpu_wr_n),
        .cpu_rd_n        (cpu_rd_n),
        .ref_col         (ref_col),
        .ref_row         (ref_row),
        .ref_visible     (ref_visible),
        .mem_addr        (mem_addr),
        .mem_we_n        (mem_we_n),
        .rd_buf_en_n     (rd_buf_en_n),
        .refresh_corrupt (refresh_corrupt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // reset state: refresh owns, R3/R4 idle strobes, R7 flag clear
        check("R3 reset", int'(mem_we_n), 1);
        check("R4 reset", int'(rd_buf_en_n), 1);
        check("R7 reset", int'(refresh_corrupt), 0);
        // R8 corners
        ref_row = 4'd0; ref_col = 6'd0; #1;
        check("R8 top-left", int'(mem_addr), 0);
        ref_row = 4'd15; ref_col = 6'd63; #1;
        check("R8 bottom-right", int'(mem_addr), 1023);
        for (int r = 0; r < 16; r++) begin
            for (int c = 0; c < 64; c++) begin
                for (int k = 0; k < 16; k++) begin
                    @(negedge clk);
                    ref_row     = 4'(r);
                    ref_col     = 6'(c);
                    cpu_addr    = 10'((r * 64 + c) ^ 10'h2A5);
                    cpu_sel_n   = k[0];
                    cpu_wr_n    = k[1];
                    cpu_rd_n    = k[2];
                    ref_visible = k[3];
                    #1;
                    if (k[0]) begin
                        check("R1/R8 refresh addr", int'(mem_addr), r * 64 + c);
                        check("R3 write held", int'(mem_we_n), 1);
                        check("R4 buffer off", int'(rd_buf_en_n), 1);
                    end else begin
                        check("R2 cpu addr", int'(mem_addr), (r * 64 + c) ^ 'h2A5);
                        check("R5 write pass", int'(mem_we_n), k[1]);
                        check("R6 read pass", int'(rd_buf_en_n), k[2]);
                    end
                    check("R7 corrupt flag", int'(refresh_corrupt), int'(!k[0] && k[3]));
                end
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule